// File: doc/BRIEF.md
# Memory Map and Select Decoder

This block sits on the address and direction lines of an 8-bit home-computer bus and turns every access into exactly one chip select: on-board RAM, system ROM, the plug-in cartridge window or a spare peripheral range. For RAM it also supplies the physical A15 line, so the upper or lower 32K half of a 64K RAM array can be placed at the bottom of the CPU's address space.

The memory layout and the CPU speed are set by four one-bit mode latches. Each latch occupies an even/odd address pair. A write to the odd address sets the bit and a write to the even address clears it. The written data does not matter. A latch changes only on a write cycle that the bus clock-enable strobe qualifies. An external slot-disable input suppresses the internal ROM and cartridge selects, so that a device on the expansion slot can answer in their place. The selects are combinational from the current address and the latched mode. A latch write takes effect on the clock edge that ends the write access.

Top module: `memmap_decoder`

## Requirements
- R1: After reset, all latches are clear: map type 0, page 0, and speed output 2'b00. Address $0000 then selects RAM with physical A15 low.
- R2: With map type 0 and page 0, addresses $0000-$7FFF assert the RAM select with physical A15 low, and addresses $8000-$BFFF assert the ROM select.
- R3: With map type 0 and page 1, addresses $0000-$7FFF assert the RAM select with physical A15 high. The ROM and cartridge areas are unchanged.
- R4: The page latch is cleared by a write to $FFD4 and set by a write to $FFD5.
- R5: The map-type latch is cleared by $FFDE and set by $FFDF. With map type 1, addresses $0000-$FEFF assert the RAM select with physical A15 equal to address bit 15. ROM and cartridge selects never assert, and the page latch has no effect on decoding, although it still stores writes.
- R6: With map type 0, addresses $C000-$FEFF assert the cartridge select for both reads and writes.
- R7: Addresses $FF40-$FF5F assert the spare select in every map type, for both reads and writes.
- R8: The speed output is {full, split}. Bit 0 is cleared by $FFD6 and set by $FFD7. Bit 1 is cleared by $FFD8 and set by $FFD9.
- R9: A latch changes only on a clock edge where the bus strobe is high and R/W is low (write). Reads of latch addresses, and writes without the strobe, leave all latches unchanged.
- R10: While slot-disable is high, the ROM and cartridge selects are held low. The RAM and spare selects are not affected.
- R11: At most one of the four selects is high at a time. Addresses $FF00-$FFFF outside the spare range assert no select, and physical A15 is low whenever the RAM select is low.
- R12: A latch write changes the latch, and every output derived from it, at the clock edge that ends the write access. Before that edge, the outputs show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus clock-enable strobe qualifying latch writes |
| addr | input | 16 | CPU address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| slot_dis | input | 1 | External slot-disable, high suppresses ROM and cartridge selects |
| ram_sel | output | 1 | RAM select |
| ram_a15 | output | 1 | Physical RAM A15 |
| rom_sel | output | 1 | System ROM select |
| cart_sel | output | 1 | Cartridge window select |
| spare_sel | output | 1 | Spare I/O range select |
| speed | output | 2 | Speed mode {full, split} |

## Verification
The decode path and the latch path can both act in the same cycle: a latch write is also an access that is being decoded, and the mode it changes steers the next access. The bench sets up a latch write, samples the speed output and selects just before the edge, where the old mode must still show. It samples again just after the edge, where the new mode must already apply. It also sweeps every address under each mode and slot-disable setting, with R/W toggling, against an arithmetic model of the map.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W    = 16;
    localparam int NUM_LATCH = 4;
    localparam int SPD_W     = 2;

    // latch indices
    localparam int LB_PAGE  = 0;
    localparam int LB_SPLIT = 1;
    localparam int LB_FULL  = 2;
    localparam int LB_MAP   = 3;

    // even (clear) address of each latch pair, index 0 in the low word
    localparam logic [NUM_LATCH-1:0][ADDR_W-1:0] LATCH_EVEN =
        {16'hFFDE, 16'hFFD8, 16'hFFD6, 16'hFFD4};

    localparam logic [ADDR_W-1:0] ROM_LO   = 16'h8000;
    localparam logic [ADDR_W-1:0] CART_LO  = 16'hC000;
    localparam logic [ADDR_W-1:0] IO_LO    = 16'hFF00;
    localparam logic [ADDR_W-1:0] SPARE_LO = 16'hFF40;
    localparam logic [ADDR_W-1:0] SPARE_HI = 16'hFF5F;

    typedef struct packed {
        logic all_ram;
        logic page;
        logic full;
        logic split;
    } mode_t;

    typedef struct packed {
        logic ram;
        logic a15;
        logic rom;
        logic cart;
        logic spare;
    } sel_t;

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic pair_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] even);
        return a[ADDR_W-1:1] == even[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/mode_latches.sv
module mode_latches
    import memmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 rd_nwr,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LATCH-1:0] bits
);

    logic wr_strobe;
    assign wr_strobe = bus_en && !rd_nwr;

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst)
                bits[i] <= 1'b0;
            else if (wr_strobe && pair_hit(addr, LATCH_EVEN[i]))
                bits[i] <= addr[0];
        end
    end

    // R9: no qualified write, no latch movement
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !rd_nwr) |=> $stable(bits));

    // R4: odd address of the page pair sets the page
    p_page_set_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !rd_nwr && addr == 16'hFFD5) |=> bits[LB_PAGE]);

    // R8: even address of the split pair clears the split bit
    p_split_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !rd_nwr && addr == 16'hFFD6) |=> !bits[LB_SPLIT]);

endmodule

// File: rtl/region_decoder.sv
module region_decoder
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  mode_t             mode,
    input  logic              slot_dis,
    output sel_t              sel
);

    logic io_area, ram_area, rom_area, cart_area;

    always_comb begin
        io_area   = addr >= IO_LO;
        ram_area  = mode.all_ram ? !io_area : (addr < ROM_LO);
        rom_area  = !mode.all_ram && (addr >= ROM_LO) && (addr < CART_LO);
        cart_area = !mode.all_ram && (addr >= CART_LO) && !io_area;

        sel.ram   = ram_area;
        sel.a15   = ram_area && (mode.all_ram ? addr[ADDR_W-1] : mode.page);
        sel.rom   = rom_area && !slot_dis;
        sel.cart  = cart_area && !slot_dis;
        sel.spare = in_range(addr, SPARE_LO, SPARE_HI);
    end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic [15:0]       addr,
    input  logic              rd_nwr,
    input  logic              slot_dis,
    output logic              ram_sel,
    output logic              ram_a15,
    output logic              rom_sel,
    output logic              cart_sel,
    output logic              spare_sel,
    output logic [1:0]        speed
);

    logic [NUM_LATCH-1:0] latch_bits;
    mode_t                mode;
    sel_t                 sel;

    mode_latches u_latches (
        .clk    (clk),
        .rst    (rst),
        .bus_en (bus_en),
        .rd_nwr (rd_nwr),
        .addr   (addr),
        .bits   (latch_bits)
    );

    always_comb begin
        mode.all_ram = latch_bits[LB_MAP];
        mode.page    = latch_bits[LB_PAGE];
        mode.full    = latch_bits[LB_FULL];
        mode.split   = latch_bits[LB_SPLIT];
    end

    region_decoder u_decode (
        .addr     (addr),
        .mode     (mode),
        .slot_dis (slot_dis),
        .sel      (sel)
    );

    assign ram_sel   = sel.ram;
    assign ram_a15   = sel.a15;
    assign rom_sel   = sel.rom;
    assign cart_sel  = sel.cart;
    assign spare_sel = sel.spare;
    assign speed     = {mode.full, mode.split};

    // R11: never two selects together
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_sel, rom_sel, cart_sel, spare_sel}));

    // R10: slot-disable silences internal ROM and cartridge
    p_slot_r10: assert property (@(posedge clk) disable iff (rst)
        slot_dis |-> (!rom_sel && !cart_sel));

    // R5: all-RAM map never selects ROM or cartridge
    p_allram_r5: assert property (@(posedge clk) disable iff (rst)
        latch_bits[LB_MAP] |-> (!rom_sel && !cart_sel));

    // R6: cartridge select only inside its window
    p_cart_win_r6: assert property (@(posedge clk) disable iff (rst)
        cart_sel |-> (addr >= 16'hC000 && addr < 16'hFF00));

    // R7: spare select only inside its range
    p_spare_win_r7: assert property (@(posedge clk) disable iff (rst)
        spare_sel |-> (addr >= 16'hFF40 && addr <= 16'hFF5F));

    // R11: physical A15 only meaningful with RAM selected
    p_a15_r11: assert property (@(posedge clk) disable iff (rst)
        ram_a15 |-> ram_sel);

endmodule

// File: tb/tb_memmap_decoder.sv
module tb_memmap_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en;
    logic [15:0] addr;
    logic        rd_nwr;
    logic        slot_dis;
    logic        ram_sel, ram_a15, rom_sel, cart_sel, spare_sel;
    logic [1:0]  speed;

    int checks = 0;
    int errors = 0;

    // bench model of the latches
    logic m_map, m_page;
    logic [1:0] m_speed;

    always #4 clk = ~clk;

    memmap_decoder dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .addr(addr), .rd_nwr(rd_nwr),
        .slot_dis(slot_dis), .ram_sel(ram_sel), .ram_a15(ram_a15),
        .rom_sel(rom_sel), .cart_sel(cart_sel), .spare_sel(spare_sel),
        .speed(speed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model(input logic [15:0] a, input logic map,
                                         input logic page, input logic sd);
        logic ram, a15, rom, cart, spare;
        ram   = map ? (a < 16'hFF00) : (a < 16'h8000);
        a15   = ram && (map ? a[15] : page);
        rom   = !map && a >= 16'h8000 && a < 16'hC000 && !sd;
        cart  = !map && a >= 16'hC000 && a < 16'hFF00 && !sd;
        spare = a >= 16'hFF40 && a <= 16'hFF5F;
        return {ram, a15, rom, cart, spare};
    endfunction

    function automatic logic [4:0] outs();
        return {ram_sel, ram_a15, rom_sel, cart_sel, spare_sel};
    endfunction

    // every address, R/W toggling, strobe low so no latch moves
    task automatic sweep(input string tag, input logic sd);
        @(negedge clk);
        bus_en = 1'b0;
        slot_dis = sd;
        for (int a = 0; a < 65536; a++) begin
            addr = a[15:0];
            rd_nwr = a[0];
            #1;
            chk({tag, $sformatf(" addr=%04h", a)}, {27'd0, outs()},
                {27'd0, model(a[15:0], m_map, m_page, sd)});
        end
        slot_dis = 1'b0;
        rd_nwr = 1'b1;
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic rnw, input logic en);
        @(negedge clk);
        addr = a; rd_nwr = rnw; bus_en = en;
        @(posedge clk);
        #1;
        @(negedge clk);
        bus_en = 1'b0; rd_nwr = 1'b1;
    endtask

    task automatic probe_ram(input string req, input logic [15:0] a, input logic [1:0] exp);
        @(negedge clk);
        addr = a; #1;
        chk(req, {30'd0, ram_sel, ram_a15}, {30'd0, exp});
    endtask

    initial begin
        #1200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_en = 1'b0; addr = 16'h0000; rd_nwr = 1'b1; slot_dis = 1'b0;
        m_map = 0; m_page = 0; m_speed = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 speed", {30'd0, speed}, 32'd0);
        probe_ram("R1 addr0", 16'h0000, 2'b10);

        // R2 R6 R7 R11 map0 page0
        sweep("R2/R6/R7/R11 map0 page0", 1'b0);
        // R10 slot disable
        sweep("R10 slot_dis", 1'b1);

        // R4 set page, R3 decode
        bus_cycle(16'hFFD5, 1'b0, 1'b1); m_page = 1;
        probe_ram("R4 page set", 16'h1234, 2'b11);
        sweep("R3 map0 page1", 1'b0);

        // R9 read of clear address with strobe, and write without strobe
        bus_cycle(16'hFFD4, 1'b1, 1'b1);
        probe_ram("R9 read ignored", 16'h0000, 2'b11);
        bus_cycle(16'hFFD4, 1'b0, 1'b0);
        probe_ram("R9 no strobe ignored", 16'h0000, 2'b11);
        bus_cycle(16'hFFDF, 1'b1, 1'b1);
        probe_ram("R9 map read ignored", 16'h8000, 2'b00);

        // R5 all-RAM map, page 1 then page 0
        bus_cycle(16'hFFDF, 1'b0, 1'b1); m_map = 1;
        sweep("R5 map1 page1", 1'b0);
        bus_cycle(16'hFFD4, 1'b0, 1'b1); m_page = 0;
        sweep("R5 map1 page0", 1'b1);
        bus_cycle(16'hFFDE, 1'b0, 1'b1); m_map = 0;
        probe_ram("R4 page cleared while map1", 16'h0100, 2'b10);

        // R8 speed latches, R12 edge timing on the split write
        @(negedge clk);
        addr = 16'hFFD7; rd_nwr = 1'b0; bus_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R12 after edge", {30'd0, speed}, 32'd1);
        @(negedge clk); bus_en = 1'b0; rd_nwr = 1'b1;
        chk("R8 split set", {30'd0, speed}, 32'd1);
        bus_cycle(16'hFFD9, 1'b0, 1'b1);
        chk("R8 full set", {30'd0, speed}, 32'd3);
        bus_cycle(16'hFFD6, 1'b0, 1'b1);
        chk("R8 split clear", {30'd0, speed}, 32'd2);
        // R12 before the edge the old value shows
        @(negedge clk);
        addr = 16'hFFD8; rd_nwr = 1'b0; bus_en = 1'b1;
        #2;
        chk("R12 before edge", {30'd0, speed}, 32'd2);
        @(posedge clk);
        #1;
        chk("R12 after edge full clear", {30'd0, speed}, 32'd0);
        @(negedge clk); bus_en = 1'b0; rd_nwr = 1'b1;
        // R12 map change steers the next access
        @(negedge clk);
        addr = 16'hFFDF; rd_nwr = 1'b0; bus_en = 1'b1;
        @(posedge clk);
        #1;
        addr = 16'h9000; #1;
        chk("R12 map applies next access", {27'd0, outs()}, {27'd0, model(16'h9000, 1'b1, 1'b0, 1'b0)});
        @(negedge clk); bus_en = 1'b0; rd_nwr = 1'b1;

        // R1 reset again clears everything
        bus_cycle(16'hFFD5, 1'b0, 1'b1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        m_map = 0; m_page = 0;
        probe_ram("R1 re-reset", 16'h0000, 2'b10);
        addr = 16'h8000; #1;
        chk("R1 rom after reset", {31'd0, rom_sel}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule